// File: doc/BRIEF.md
# ALU, Shift and Branch Execute Unit

This block is the execute stage of a small 32-bit RISC core. Each instruction computes Rw = Ra Function Rb. A second field, the op, then does one of three things. It can shift or rotate the ALU result by a 5-bit count. It can pass the result through unchanged. It can choose a jump condition that is tested against the ALU result.

The decoder supplies the function code, the op code, the count, two operands and an optional constant. The unit returns a registered result, a carry flag and a jump-taken flag. Three op codes belong to the queue and load-link datapaths, which live outside this block. For those ops the unit passes the ALU output through unshifted and raises a flag on a side output, so the caller can route them.

Top module: `xu_exec`

## Requirements
- R1: The function code selects the ALU operation: 0 = A+B, 1 = A-B, 2 = A&B, 3 = A&~B, 4 = A|B, 5 = A|~B, 6 = A^B, 7 = A^~B. With op 5, the ALU output is the result, with no shift.
- R2: Carry is the carry-out of A+B for function 0 and the carry-out of A+~B+1 for function 1. It is 0 for functions 2 to 7, whatever the op.
- R3: Op 0 shifts the ALU output right logically, op 1 shifts it left, and op 4 shifts it right arithmetically. Each shift is by the 5-bit count.
- R4: Op 2 rotates the ALU output right by the count, and op 3 rotates it left by the count.
- R5: For ops 0 to 4, a count of 0 leaves the ALU output unchanged.
- R6: Ops 9 to 15 set jump_o from the unshifted ALU output Y and the carry, as follows:
  - 9: Y[31] = 1
  - 10: Y = 0
  - 11: carry = 1
  - 12: always
  - 13: Y[31] = 0
  - 14: Y != 0
  - 15: carry = 0

  For these ops the result is Y, unshifted. For ops 0 to 8, jump_o is 0.
- R7: Ops 6, 7 and 8 set special_o and pass Y through unshifted, with jump_o at 0. For every other op, special_o is 0.
- R8: When const_sel_i is 1, const_i replaces operand B at the ALU input.
- R9: The result, carry, jump and special outputs load on a rising clock edge only when valid_i is 1. Otherwise they hold their values.
- R10: While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture enable |
| func_i | input | 3 | ALU function code |
| op_i | input | 4 | Post-ALU op or jump condition |
| count_i | input | 5 | Shift or rotate amount |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| const_sel_i | input | 1 | Use const_i in place of B |
| const_i | input | 32 | Constant operand |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered ALU carry |
| jump_o | output | 1 | Registered jump-taken |
| special_o | output | 1 | Registered flag for ops 6 to 8 |

## Verification
The bench targets several corner cases, and each one shows up as a specific wrong output:
- **Counts 0 and 31 on rotates.** A rotate built from two opposite shifts can smear or drop bits at these counts.
- **Arithmetic shift of a negative value.** Filling the top with zeros instead of sign bits gives a wrong high half.
- **Subtracting equal operands.** The result is zero, but the carry must be 1. A design that takes the borrow polarity for carry flips the outcomes of ops 11 and 15.
- **Jump conditions on a result with bit 31 set.** These show whether the condition is tested on the shifted value instead of the raw ALU output.

The bench also checks two more behaviours:
- A stall cycle with changed inputs must leave all outputs unchanged.
- A logic function must never report a carry, even when its operands would carry if added.

// File: rtl/xu_pkg.sv
package xu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0, FN_SUB  = 3'd1, FN_AND = 3'd2, FN_ANDN = 3'd3,
    FN_OR   = 3'd4, FN_ORN  = 3'd5, FN_XOR = 3'd6, FN_XNOR = 3'd7
  } fn_e;

  typedef enum logic [3:0] {
    OP_SHR  = 4'd0,  OP_SHL  = 4'd1,  OP_ROR  = 4'd2,  OP_ROL  = 4'd3,
    OP_SAR  = 4'd4,  OP_PASS = 4'd5,  OP_QWR  = 4'd6,  OP_QRD  = 4'd7,
    OP_LLI  = 4'd8,  OP_JNEG = 4'd9,  OP_JZ   = 4'd10, OP_JC   = 4'd11,
    OP_JMP  = 4'd12, OP_JPOS = 4'd13, OP_JNZ  = 4'd14, OP_JNC  = 4'd15
  } op_e;
endpackage

// File: rtl/xu_alu.sv
module xu_alu #(
  parameter int unsigned W = 32
) (
  input  xu_pkg::fn_e    fn_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   y_o,
  output logic           c_o
);
  import xu_pkg::*;

  logic [W:0] sum;

  // subtraction shares the adder as a + ~b + 1
  always_comb begin
    if (fn_i == FN_SUB) sum = {1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, 1'b1};
    else                sum = {1'b0, a_i} + {1'b0, b_i};
  end

  always_comb begin
    c_o = 1'b0;
    unique case (fn_i)
      FN_ADD, FN_SUB: begin y_o = sum[W-1:0]; c_o = sum[W]; end
      FN_AND:  y_o = a_i & b_i;
      FN_ANDN: y_o = a_i & ~b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_ORN:  y_o = a_i | ~b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_XNOR: y_o = a_i ^ ~b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/xu_shifter.sv
module xu_shifter #(
  parameter int unsigned W  = 32,
  localparam int unsigned CW = $clog2(W)
) (
  input  xu_pkg::op_e    op_i,
  input  logic [CW-1:0]  cnt_i,
  input  logic [W-1:0]   d_i,
  output logic [W-1:0]   q_o
);
  import xu_pkg::*;

  logic [2*W-1:0] dbl_r, dbl_l;

  // rotates taken from a doubled word
  assign dbl_r = {d_i, d_i} >> cnt_i;
  assign dbl_l = {d_i, d_i} << cnt_i;

  always_comb begin
    unique case (op_i)
      OP_SHR:  q_o = d_i >> cnt_i;
      OP_SHL:  q_o = d_i << cnt_i;
      OP_ROR:  q_o = dbl_r[W-1:0];
      OP_ROL:  q_o = dbl_l[2*W-1:W];
      OP_SAR:  q_o = W'($signed(d_i) >>> cnt_i);
      default: q_o = d_i;
    endcase
  end
endmodule

// File: rtl/xu_jump_cond.sv
module xu_jump_cond #(
  parameter int unsigned W = 32
) (
  input  xu_pkg::op_e    op_i,
  input  logic [W-1:0]   y_i,
  input  logic           c_i,
  output logic           take_o
);
  import xu_pkg::*;

  logic neg, zero;
  assign neg  = y_i[W-1];
  assign zero = (y_i == '0);

  always_comb begin
    unique case (op_i)
      OP_JNEG: take_o = neg;
      OP_JZ:   take_o = zero;
      OP_JC:   take_o = c_i;
      OP_JMP:  take_o = 1'b1;
      OP_JPOS: take_o = ~neg;
      OP_JNZ:  take_o = ~zero;
      OP_JNC:  take_o = ~c_i;
      default: take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/xu_exec.sv
module xu_exec #(
  parameter int unsigned DATA_W = xu_pkg::DATA_W,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        func_i,
  input  logic [3:0]        op_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              const_sel_i,
  input  logic [DATA_W-1:0] const_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              jump_o,
  output logic              special_o
);
  import xu_pkg::*;

  fn_e               fn;
  op_e               op;
  logic [DATA_W-1:0] b_sel, alu_y, sh_q;
  logic              alu_c, take, spec;

  assign fn    = fn_e'(func_i);
  assign op    = op_e'(op_i);
  assign b_sel = const_sel_i ? const_i : opb_i;
  assign spec  = (op == OP_QWR) || (op == OP_QRD) || (op == OP_LLI);

  xu_alu #(.W(DATA_W)) u_alu (
    .fn_i(fn), .a_i(opa_i), .b_i(b_sel), .y_o(alu_y), .c_o(alu_c)
  );

  xu_shifter #(.W(DATA_W)) u_sh (
    .op_i(op), .cnt_i(count_i), .d_i(alu_y), .q_o(sh_q)
  );

  xu_jump_cond #(.W(DATA_W)) u_jc (
    .op_i(op), .y_i(alu_y), .c_i(alu_c), .take_o(take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      carry_o   <= 1'b0;
      jump_o    <= 1'b0;
      special_o <= 1'b0;
    end else if (valid_i) begin
      result_o  <= sh_q;
      carry_o   <= alu_c;
      jump_o    <= take;
      special_o <= spec;
    end
  end
endmodule

module xu_exec_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        func_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o,
  input logic              jump_o,
  input logic              special_o
);
  // R9
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(carry_o) && $stable(jump_o) && $stable(special_o));

  // R2
  logic_no_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && func_i >= 3'd2) |=> !carry_o);

  // R6
  always_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 4'd12) |=> jump_o);

  // R6
  no_jump_low_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 4'd8) |=> !jump_o);

  // R7
  special_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (special_o == ($past(op_i) >= 4'd6 && $past(op_i) <= 4'd8)));

  // R7
  special_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(special_o && jump_o));
endmodule

bind xu_exec xu_exec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .func_i(func_i),
  .op_i(op_i), .result_o(result_o), .carry_o(carry_o), .jump_o(jump_o),
  .special_o(special_o)
);

// File: tb/xu_exec_test.sv
module xu_exec_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  func_i = '0;
  logic [3:0]  op_i = '0;
  logic [4:0]  count_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0, const_i = '0;
  logic        const_sel_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, jump_o, special_o;

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] m_res = '0;
  logic        m_c = 1'b0, m_j = 1'b0, m_s = 1'b0;

  always #2 clk_i = ~clk_i;

  xu_exec uut (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    if (op == 5) return "R1";
    if (op == 0 || op == 1 || op == 4) return "R3";
    if (op == 2 || op == 3) return "R4";
    if (op >= 6 && op <= 8) return "R7";
    return "R6";
  endfunction

  // behavioural reference for one capture
  task automatic model(input int fn, input int op, input int cnt,
                       input longint a, input longint b);
    longint y, s, r;
    logic c, neg, z;
    c = 1'b0;
    case (fn)
      0: begin s = a + b; y = s & 64'hFFFF_FFFF; c = s[32]; end
      1: begin s = a + ((~b) & 64'hFFFF_FFFF) + 1; y = s & 64'hFFFF_FFFF; c = s[32]; end
      2: y = a & b;
      3: y = a & ~b;
      4: y = a | b;
      5: y = a | ~b;
      6: y = a ^ b;
      default: y = a ^ ~b;
    endcase
    y = y & 64'hFFFF_FFFF;
    neg = y[31];
    z = (y == 0);
    r = y;
    case (op)
      0: r = y >> cnt;
      1: r = (y << cnt) & 64'hFFFF_FFFF;
      2: r = ((y >> cnt) | (y << (32 - cnt))) & 64'hFFFF_FFFF;
      3: r = ((y << cnt) | (y >> (32 - cnt))) & 64'hFFFF_FFFF;
      4: begin
        r = y >> cnt;
        if (neg) for (int k = 0; k < cnt; k++) r[31-k] = 1'b1;
      end
      default: r = y;
    endcase
    m_res = r[31:0];
    m_c = c;
    m_s = (op >= 6 && op <= 8);
    case (op)
      9: m_j = neg;
      10: m_j = z;
      11: m_j = c;
      12: m_j = 1'b1;
      13: m_j = !neg;
      14: m_j = !z;
      15: m_j = !c;
      default: m_j = 1'b0;
    endcase
  endtask

  task automatic step(input bit v, input int fn, input int op, input int cnt,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit cs, input logic [31:0] k, input string tag);
    @(negedge clk_i);
    valid_i = v; func_i = 3'(fn); op_i = 4'(op); count_i = 5'(cnt);
    opa_i = a; opb_i = b; const_sel_i = cs; const_i = k;
    if (v) model(fn, op, cnt, {32'd0, a}, {32'd0, cs ? k : b});
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk((tag != "") ? tag : op_tag(op), result_o, m_res);
    chk("R2", {31'd0, carry_o}, {31'd0, m_c});
    chk((tag != "") ? tag : ((op >= 6 && op <= 8) ? "R7" : "R6"), {31'd0, jump_o}, {31'd0, m_j});
    chk("R7", {31'd0, special_o}, {31'd0, m_s});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10", result_o, 32'd0);
    chk("R10", {29'd0, carry_o, jump_o, special_o}, 32'd0);
    rst_ni = 1'b1;

    // R1 functions, pass-through
    for (int f = 0; f < 8; f++) step(1, f, 5, 7, 32'hF0F0_1234, 32'h0FF0_8765, 0, 0, "R1");
    // R2 carry cases
    step(1, 0, 5, 0, 32'hFFFF_FFFF, 32'h1, 0, 0, "R2");
    step(1, 1, 5, 0, 32'h5, 32'h5, 0, 0, "R2");
    step(1, 1, 5, 0, 32'h4, 32'h5, 0, 0, "R2");
    step(1, 2, 5, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R2");
    // R3 / R4 / R5 shifts and rotates at edges
    for (int o = 0; o < 5; o++) begin
      step(1, 4, o, 0, 32'h8000_0F01, 0, 0, 0, "R5");
      step(1, 4, o, 1, 32'h8000_0F01, 0, 0, 0, "");
      step(1, 4, o, 31, 32'h8000_0F01, 0, 0, 0, "");
      step(1, 4, o, 13, 32'h8765_4321, 0, 0, 0, "");
    end
    // R6 jumps on unshifted value, incl. zero and negative
    for (int o = 9; o < 16; o++) begin
      step(1, 1, o, 3, 32'h7, 32'h7, 0, 0, "R6");
      step(1, 0, o, 3, 32'h8000_0000, 32'h1, 0, 0, "R6");
      step(1, 0, o, 3, 32'hFFFF_FFFF, 32'h2, 0, 0, "R6");
    end
    // R7 special ops
    for (int o = 6; o < 9; o++) step(1, 0, o, 9, 32'h1234_0000, 32'h5678, 0, 0, "R7");
    // R8 constant select
    step(1, 0, 5, 0, 32'h100, 32'hDEAD_0000, 1, 32'h23, "R8");
    step(1, 1, 1, 4, 32'h100, 32'h1, 1, 32'h40, "R8");
    // R9 stall: inputs change, outputs hold
    step(1, 6, 2, 8, 32'hCAFE_BABE, 32'h1111_1111, 0, 0, "R9");
    step(0, 0, 12, 1, 32'h0, 32'h0, 0, 0, "R9");
    step(0, 1, 15, 5, 32'hFFFF_FFFF, 32'h0, 1, 32'h9, "R9");
    // random sweep
    for (int i = 0; i < 400; i++)
      step(1, int'($urandom_range(7)), int'($urandom_range(15)), int'($urandom_range(31)),
           $urandom, $urandom, 1'($urandom_range(1)), $urandom, "");
    // R10 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R10", result_o, 32'd0);
    chk("R10", {29'd0, carry_o, jump_o, special_o}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule